// File: doc/BRIEF.md
# Atomic Compare-and-Exchange Memory Unit

This execution unit carries out one double-width compare-and-exchange against a single memory location. A command supplies a comparand split into a high and a low register half, a replacement value split the same way, a byte address, an operand-size select, a feature-enable bit and a "destination is not memory" marker. The unit reads the location under a bus lock, compares it with the comparand, and then always writes the location while still locked. The replacement is written on a match. On a mismatch the value just read goes back unchanged and is returned through the result halves.

The command port is valid/ready: `cmd_ready` is high only while the unit is idle, and a command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. The memory request port is also valid/ready. The unit holds a request, including its address, direction and data, until `mem_req_ready` accepts it. Responses have no back-pressure. `mem_rsp_valid` is honoured only after the outstanding request has been accepted, and it must come at least one cycle after acceptance. For a read it carries the data. For a write it is the acknowledge. The result appears with a one-cycle `done` pulse.

Top module: `cas_unit`

## Requirements
- R1: In wide mode (`cmd_wide`=1) the operand is the full high:low register pair, 128 bits. In narrow mode only bits [31:0] of each register are used, so the operand is 64 bits with the high register supplying the upper 32 bits. Only memory data bits [63:0] take part.
- R2: When memory equals the operand, flag bit 6 (zero flag) is set to 1, the replacement is written, and `res_hi`/`res_lo` return the comparand registers unchanged.
- R3: On a mismatch, flag bit 6 is cleared to 0 and the memory value is returned in the halves. In narrow mode `res_hi` = zero-extended memory bits [63:32] and `res_lo` = zero-extended bits [31:0].
- R4: Every command without a fault makes exactly one read and then exactly one write to the command address. On a mismatch the write stores the value read, so memory is left unchanged.
- R5: `mem_lock` is high from the read request until the write acknowledge, and on every request. It falls in the cycle where `done` rises.
- R6: Write byte enables are 0x00FF in narrow mode and 0xFFFF in wide mode.
- R7: A wide command whose address bits [3:0] are not zero ends with fault code 1 (general protection) and makes no memory access.
- R8: A wide command with `wide_en`=0 ends with fault code 1 and makes no memory access.
- R9: A command with `cmd_not_mem`=1 ends with fault code 2 (undefined opcode), whatever the other checks say, and makes no memory access. Code 0 means no fault.
- R10: Only flag bit 6 of `flags_in` is replaced, and all other flag bits pass through. On a fault the flags come back untouched, and `zf` always equals `flags_out` bit 6.
- R11: `done` is a one-cycle pulse, `cmd_ready` is low while a command is in progress, and an unaccepted memory request is held stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle, command accepted |
| cmd_wide | input | 1 | Select 128-bit operand size |
| cmd_not_mem | input | 1 | Destination is a register, not memory |
| wide_en | input | 1 | 128-bit operation enabled |
| cmd_addr | input | AW | Byte address of the location |
| cmp_hi | input | HALF_W | Comparand high register |
| cmp_lo | input | HALF_W | Comparand low register |
| new_hi | input | HALF_W | Replacement high register |
| new_lo | input | HALF_W | Replacement low register |
| flags_in | input | FLAG_W | Incoming flags word |
| done | output | 1 | One-cycle result strobe |
| zf | output | 1 | Zero flag result |
| fault | output | 2 | 0 none, 1 general protection, 2 undefined opcode |
| flags_out | output | FLAG_W | Flags with zero flag updated |
| res_hi | output | HALF_W | Updated comparand high register |
| res_lo | output | HALF_W | Updated comparand low register |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | Request is a write |
| mem_req_addr | output | AW | Request address |
| mem_req_wdata | output | 2*HALF_W | Write data |
| mem_req_be | output | 2*HALF_W/8 | Write byte enables |
| mem_lock | output | 1 | Bus lock |
| mem_rsp_valid | input | 1 | Read data or write acknowledge |
| mem_rsp_rdata | input | 2*HALF_W | Read data |

## Verification
The hardest case to reach is a locked window that back-pressure stretches: a request held for several cycles before acceptance, followed by a late response, while the lock has to stay high through the compare stage and the write. The bench memory lowers its ready at random and picks a random response latency for every request. Because of this, both the read and the write phase are stalled in many different ways during a long run of mixed match and mismatch commands. The fault cases are placed between normal commands, so the bench can see that they cause no bus activity at all.

// File: rtl/cas_pkg.sv
package cas_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_COMPARE, ST_WRITE, ST_DONE
  } cas_state_t;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_GP   = 2'd1,
    FLT_UD   = 2'd2
  } cas_fault_t;
endpackage

// File: rtl/cas_fault_check.sv
module cas_fault_check
  import cas_pkg::*;
#(
  parameter int ALIGN_BITS = 4
) (
  input  logic                  wide,
  input  logic                  not_mem,
  input  logic                  wide_en,
  input  logic [ALIGN_BITS-1:0] addr_lo,
  output cas_fault_t            fault
);
  // Priority: register destination first, then feature, then alignment.
  always_comb begin
    if (not_mem)
      fault = FLT_UD;
    else if (wide && !wide_en)
      fault = FLT_GP;
    else if (wide && (addr_lo != '0))
      fault = FLT_GP;
    else
      fault = FLT_NONE;
  end
endmodule

// File: rtl/cas_datapath.sv
module cas_datapath #(
  parameter int HALF_W = 64
) (
  input  logic                wide,
  input  logic [HALF_W-1:0]   cmp_hi,
  input  logic [HALF_W-1:0]   cmp_lo,
  input  logic [HALF_W-1:0]   new_hi,
  input  logic [HALF_W-1:0]   new_lo,
  input  logic [2*HALF_W-1:0] rd,
  output logic                match,
  output logic [2*HALF_W-1:0] wdata,
  output logic [2*HALF_W/8-1:0] be,
  output logic [HALF_W-1:0]   res_hi,
  output logic [HALF_W-1:0]   res_lo
);
  localparam int DATA_W = 2 * HALF_W;
  localparam int NW     = HALF_W / 2;
  localparam int BE_W   = DATA_W / 8;

  logic [HALF_W-1:0] cmp_narrow, new_narrow;
  logic [DATA_W-1:0] new_full;

  assign cmp_narrow = {cmp_hi[NW-1:0], cmp_lo[NW-1:0]};
  assign new_narrow = {new_hi[NW-1:0], new_lo[NW-1:0]};

  always_comb begin
    if (wide) begin
      match    = (rd == {cmp_hi, cmp_lo});
      new_full = {new_hi, new_lo};
    end else begin
      match    = (rd[HALF_W-1:0] == cmp_narrow);
      new_full = {rd[DATA_W-1:HALF_W], new_narrow};
    end
    wdata = match ? new_full : rd;
  end

  always_comb begin
    if (match) begin
      res_hi = cmp_hi;
      res_lo = cmp_lo;
    end else if (wide) begin
      res_hi = rd[DATA_W-1:HALF_W];
      res_lo = rd[HALF_W-1:0];
    end else begin
      res_hi = {{NW{1'b0}}, rd[HALF_W-1:NW]};
      res_lo = {{NW{1'b0}}, rd[NW-1:0]};
    end
  end

  for (genvar g = 0; g < BE_W; g++) begin : g_be
    if (g < BE_W / 2) begin : g_low
      assign be[g] = 1'b1;
    end else begin : g_high
      assign be[g] = wide;
    end
  end
endmodule

// File: rtl/cas_seq.sv
module cas_seq
  import cas_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic cmd_faulty,
  output logic cmd_ready,
  output logic cmd_fire,
  output logic mem_req_valid,
  input  logic mem_req_ready,
  output logic mem_req_write,
  output logic mem_lock,
  input  logic mem_rsp_valid,
  output logic rd_fire,
  output logic cmp_stage,
  output logic done
);
  cas_state_t state;
  logic       issued;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      issued <= 1'b0;
    end else begin
      case (state)
        ST_IDLE:
          if (cmd_valid) state <= cmd_faulty ? ST_DONE : ST_READ;
        ST_READ, ST_WRITE: begin
          if (mem_req_valid && mem_req_ready) issued <= 1'b1;
          if (issued && mem_rsp_valid) begin
            issued <= 1'b0;
            state  <= (state == ST_READ) ? ST_COMPARE : ST_DONE;
          end
        end
        ST_COMPARE: state <= ST_WRITE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready     = (state == ST_IDLE);
  assign cmd_fire      = cmd_valid && cmd_ready;
  assign mem_req_valid = ((state == ST_READ) || (state == ST_WRITE)) && !issued;
  assign mem_req_write = (state == ST_WRITE);
  assign mem_lock      = (state == ST_READ) || (state == ST_COMPARE) || (state == ST_WRITE);
  assign rd_fire       = (state == ST_READ) && issued && mem_rsp_valid;
  assign cmp_stage     = (state == ST_COMPARE);
  assign done          = (state == ST_DONE);
endmodule

// File: rtl/cas_unit.sv
module cas_unit
  import cas_pkg::*;
#(
  parameter int HALF_W = 64,
  parameter int AW     = 32,
  parameter int FLAG_W = 8,
  parameter int ZF_POS = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  output logic                   cmd_ready,
  input  logic                   cmd_wide,
  input  logic                   cmd_not_mem,
  input  logic                   wide_en,
  input  logic [AW-1:0]          cmd_addr,
  input  logic [HALF_W-1:0]      cmp_hi,
  input  logic [HALF_W-1:0]      cmp_lo,
  input  logic [HALF_W-1:0]      new_hi,
  input  logic [HALF_W-1:0]      new_lo,
  input  logic [FLAG_W-1:0]      flags_in,
  output logic                   done,
  output logic                   zf,
  output logic [1:0]             fault,
  output logic [FLAG_W-1:0]      flags_out,
  output logic [HALF_W-1:0]      res_hi,
  output logic [HALF_W-1:0]      res_lo,
  output logic                   mem_req_valid,
  input  logic                   mem_req_ready,
  output logic                   mem_req_write,
  output logic [AW-1:0]          mem_req_addr,
  output logic [2*HALF_W-1:0]    mem_req_wdata,
  output logic [2*HALF_W/8-1:0]  mem_req_be,
  output logic                   mem_lock,
  input  logic                   mem_rsp_valid,
  input  logic [2*HALF_W-1:0]    mem_rsp_rdata
);
  localparam int DATA_W     = 2 * HALF_W;
  localparam int BE_W       = DATA_W / 8;
  localparam int ALIGN_BITS = $clog2(BE_W);

  cas_fault_t fault_c, fault_q;
  logic       cmd_fire, rd_fire, cmp_stage;

  logic              op_wide;
  logic [AW-1:0]     op_addr;
  logic [HALF_W-1:0] op_chi, op_clo, op_nhi, op_nlo;
  logic [FLAG_W-1:0] op_flags, flags_q, flags_next;
  logic [DATA_W-1:0] rd_q, wdata_q;
  logic [HALF_W-1:0] res_hi_q, res_lo_q;

  logic              dp_match;
  logic [DATA_W-1:0] dp_wdata;
  logic [BE_W-1:0]   dp_be;
  logic [HALF_W-1:0] dp_res_hi, dp_res_lo;

  cas_fault_check #(.ALIGN_BITS(ALIGN_BITS)) u_fault (
    .wide    (cmd_wide),
    .not_mem (cmd_not_mem),
    .wide_en (wide_en),
    .addr_lo (cmd_addr[ALIGN_BITS-1:0]),
    .fault   (fault_c)
  );

  cas_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_faulty    (fault_c != FLT_NONE),
    .cmd_ready     (cmd_ready),
    .cmd_fire      (cmd_fire),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_lock      (mem_lock),
    .mem_rsp_valid (mem_rsp_valid),
    .rd_fire       (rd_fire),
    .cmp_stage     (cmp_stage),
    .done          (done)
  );

  cas_datapath #(.HALF_W(HALF_W)) u_dp (
    .wide   (op_wide),
    .cmp_hi (op_chi),
    .cmp_lo (op_clo),
    .new_hi (op_nhi),
    .new_lo (op_nlo),
    .rd     (rd_q),
    .match  (dp_match),
    .wdata  (dp_wdata),
    .be     (dp_be),
    .res_hi (dp_res_hi),
    .res_lo (dp_res_lo)
  );

  always_comb begin
    flags_next         = op_flags;
    flags_next[ZF_POS] = dp_match;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_wide  <= 1'b0;
      op_addr  <= '0;
      op_chi   <= '0;
      op_clo   <= '0;
      op_nhi   <= '0;
      op_nlo   <= '0;
      op_flags <= '0;
      fault_q  <= FLT_NONE;
      rd_q     <= '0;
      wdata_q  <= '0;
      res_hi_q <= '0;
      res_lo_q <= '0;
      flags_q  <= '0;
    end else begin
      if (cmd_fire) begin
        op_wide  <= cmd_wide;
        op_addr  <= cmd_addr;
        op_chi   <= cmp_hi;
        op_clo   <= cmp_lo;
        op_nhi   <= new_hi;
        op_nlo   <= new_lo;
        op_flags <= flags_in;
        fault_q  <= fault_c;
        if (fault_c != FLT_NONE) begin
          res_hi_q <= cmp_hi;
          res_lo_q <= cmp_lo;
          flags_q  <= flags_in;
        end
      end
      if (rd_fire) rd_q <= mem_rsp_rdata;
      if (cmp_stage) begin
        res_hi_q <= dp_res_hi;
        res_lo_q <= dp_res_lo;
        wdata_q  <= dp_wdata;
        flags_q  <= flags_next;
      end
    end
  end

  assign mem_req_addr  = op_addr;
  assign mem_req_wdata = wdata_q;
  assign mem_req_be    = dp_be;
  assign fault         = fault_q;
  assign flags_out     = flags_q;
  assign zf            = flags_q[ZF_POS];
  assign res_hi        = res_hi_q;
  assign res_lo        = res_lo_q;
endmodule

// File: rtl/cas_unit_chk.sv
module cas_unit_chk #(
  parameter int AW     = 32,
  parameter int DATA_W = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              done,
  input logic [1:0]        fault,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [AW-1:0]     mem_req_addr,
  input logic [DATA_W-1:0] mem_req_wdata,
  input logic [DATA_W/8-1:0] mem_req_be,
  input logic              mem_lock
);
  localparam int BE_W = DATA_W / 8;

  p_lock_on_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_lock);

  p_release_after_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_lock) |-> ($past(mem_req_write) && done));

  p_be_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> ((mem_req_be == {BE_W{1'b1}}) ||
                       (mem_req_be == {{(BE_W/2){1'b0}}, {(BE_W/2){1'b1}}})));

  p_fault_no_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault != 2'd0) |-> !$past(mem_lock));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_lock |-> !cmd_ready);

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_write) && $stable(mem_req_addr) &&
       $stable(mem_req_wdata)));
endmodule

bind cas_unit cas_unit_chk #(.AW(AW), .DATA_W(2*HALF_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_ready     (cmd_ready),
  .done          (done),
  .fault         (fault),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata),
  .mem_req_be    (mem_req_be),
  .mem_lock      (mem_lock)
);

// File: tb/sim_cas_unit.sv
`timescale 1ns/1ps
module sim_cas_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic         cmd_valid = 0, cmd_ready, cmd_wide = 0, cmd_not_mem = 0, wide_en = 1;
  logic [31:0]  cmd_addr = 0;
  logic [63:0]  cmp_hi = 0, cmp_lo = 0, new_hi = 0, new_lo = 0;
  logic [7:0]   flags_in = 0, flags_out;
  logic         done, zf;
  logic [1:0]   fault;
  logic [63:0]  res_hi, res_lo;
  logic         mem_req_valid, mem_req_ready = 0, mem_req_write, mem_lock;
  logic [31:0]  mem_req_addr;
  logic [127:0] mem_req_wdata, mem_rsp_rdata = 0;
  logic [15:0]  mem_req_be;
  logic         mem_rsp_valid = 0;

  cas_unit u0 (.*);

  int n_chk = 0, n_fail = 0;
  logic [127:0] mem [int unsigned];
  int  n_rd = 0, n_wr = 0;
  logic [15:0] exp_be = 0;
  bit  in_rmw = 0, pend = 0, pend_wr = 0;
  int  lat = 0;
  logic [127:0] pend_data = 0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Memory model with random back-pressure and response latency.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) continue;
      if (in_rmw) chk(mem_lock == 1'b1, "R5 lock held in locked window", mem_lock, 1);
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (lat == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_rdata = pend_data;
          pend = 0;
          if (pend_wr) in_rmw = 0;
        end else lat--;
      end
      mem_req_ready = (!pend && !mem_rsp_valid) ? (($urandom % 3) != 0) : 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        logic [127:0] cur;
        cur = mem.exists(mem_req_addr) ? mem[mem_req_addr] : '0;
        pend = 1;
        lat  = $urandom % 3;
        chk(mem_lock == 1'b1, "R5 lock on request", mem_lock, 1);
        if (mem_req_write) begin
          n_wr++;
          pend_wr = 1;
          pend_data = '0;
          chk(mem_req_be == exp_be, "R6 byte enables", mem_req_be, exp_be);
          for (int b = 0; b < 16; b++)
            if (mem_req_be[b]) cur[b*8 +: 8] = mem_req_wdata[b*8 +: 8];
          mem[mem_req_addr] = cur;
        end else begin
          chk(n_wr == n_rd, "R4 read only after previous write", n_rd, n_wr);
          n_rd++;
          pend_wr = 0;
          pend_data = cur;
          in_rmw = 1;
        end
      end
    end
  end

  task automatic run_op(input bit wide, input bit nm, input bit en, input logic [31:0] a,
                        input logic [63:0] ch, input logic [63:0] cl,
                        input logic [63:0] nh, input logic [63:0] nl,
                        input logic [7:0] fl, input string tag);
    logic [127:0] m, m_after, cmpv;
    logic [1:0]   e_fault;
    logic [63:0]  e_hi, e_lo;
    logic [7:0]   e_fl;
    bit           eq;
    int           rd0, wr0, guard;
    m = mem.exists(a) ? mem[a] : '0;
    m_after = m;
    e_hi = ch; e_lo = cl; e_fl = fl;
    if (nm) e_fault = 2;
    else if (wide && !en) e_fault = 1;
    else if (wide && a[3:0] != 0) e_fault = 1;
    else e_fault = 0;
    if (e_fault == 0) begin
      if (wide) begin
        cmpv = {ch, cl};
        eq = (m == cmpv);
        if (eq) m_after = {nh, nl};
        else begin e_hi = m[127:64]; e_lo = m[63:0]; end
      end else begin
        cmpv = {64'd0, ch[31:0], cl[31:0]};
        eq = (m[63:0] == cmpv[63:0]);
        if (eq) m_after = {m[127:64], nh[31:0], nl[31:0]};
        else begin e_hi = {32'd0, m[63:32]}; e_lo = {32'd0, m[31:0]}; end
      end
      e_fl[6] = eq;
    end
    exp_be = wide ? 16'hFFFF : 16'h00FF;
    rd0 = n_rd; wr0 = n_wr;
    @(negedge clk);
    cmd_valid = 1; cmd_wide = wide; cmd_not_mem = nm; wide_en = en; cmd_addr = a;
    cmp_hi = ch; cmp_lo = cl; new_hi = nh; new_lo = nl; flags_in = fl;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
    chk(!cmd_ready || done, "R11 busy after accept", cmd_ready, 0);
    guard = 0;
    while (!done && guard < 200) begin @(negedge clk); guard++; end
    chk(done == 1'b1, {"R11 done seen ", tag}, done, 1);
    chk(fault == e_fault, {"R7 R8 R9 fault code ", tag}, fault, e_fault);
    chk(flags_out == e_fl, {"R10 flags ", tag}, flags_out, e_fl);
    chk(zf == e_fl[6], {"R2 R3 zf ", tag}, zf, e_fl[6]);
    chk(res_hi == e_hi, {"R1 R3 res_hi ", tag}, res_hi, e_hi);
    chk(res_lo == e_lo, {"R1 R3 res_lo ", tag}, res_lo, e_lo);
    chk(mem_lock == 1'b0, {"R5 lock released at done ", tag}, mem_lock, 0);
    chk((n_rd - rd0) == (e_fault == 0 ? 1 : 0), {"R4 R9 read count ", tag}, n_rd - rd0, e_fault == 0);
    chk((n_wr - wr0) == (e_fault == 0 ? 1 : 0), {"R4 R9 write count ", tag}, n_wr - wr0, e_fault == 0);
    chk(mem[a] == m_after || (!mem.exists(a) && m_after == 0), {"R2 R4 memory after ", tag},
        mem.exists(a) ? mem[a] : '0, m_after);
    @(negedge clk);
    chk(done == 1'b0, {"R11 done pulse width ", tag}, done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    mem[32'h100] = {64'hAAAA_BBBB_CCCC_DDDD, 64'h1111_2222_3333_4444};
    mem[32'h104] = 128'h5;
    mem[32'h200] = {64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210};
    mem[32'h208] = 128'h77;
    mem[32'h300] = 128'h99;
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1 && done == 0 && mem_lock == 0 && mem_req_valid == 0,
        "R11 reset state", {cmd_ready, done, mem_lock, mem_req_valid}, 4'b1000);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // R1 R2: narrow match; upper register bits are junk and must be ignored.
    run_op(0, 0, 1, 32'h100, 64'hDEAD_0000_1111_2222, 64'hBEEF_0000_3333_4444,
           64'hFFFF_0000_5555_6666, 64'hEEEE_0000_7777_8888, 8'h81, "narrow match");
    // R3 R4: narrow mismatch keeps memory, returns zero-extended halves.
    run_op(0, 0, 1, 32'h100, 64'h1, 64'h2, 64'h3, 64'h4, 8'h45, "narrow mismatch");
    // R2 R6: wide match.
    run_op(1, 0, 1, 32'h200, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210,
           64'hCAFE_F00D_0000_0001, 64'h1234_0000_0000_0002, 8'h00, "wide match");
    // R3: wide mismatch.
    run_op(1, 0, 1, 32'h200, 64'h0, 64'h0, 64'h9, 64'h9, 8'hFF, "wide mismatch");
    // R7: wide misaligned.
    run_op(1, 0, 1, 32'h208, 64'h0, 64'h77, 64'h1, 64'h1, 8'h3C, "wide misaligned");
    // R8: wide disabled.
    run_op(1, 0, 0, 32'h300, 64'h0, 64'h99, 64'h1, 64'h1, 8'h40, "wide disabled");
    // R9: not memory wins over alignment and enable faults.
    run_op(1, 1, 0, 32'h208, 64'h5, 64'h6, 64'h7, 64'h8, 8'h02, "not memory");
    // R1: narrow operand at an address not 16-byte aligned is legal.
    run_op(0, 0, 1, 32'h104, 64'h0, 64'h5, 64'h0, 64'hABCD, 8'h00, "narrow at 0x104");
    // Mixed stream under random back-pressure.
    for (int i = 0; i < 60; i++) begin
      logic [31:0]  a;
      logic [127:0] cur;
      bit           w, hit;
      logic [63:0]  ch, cl;
      w = $urandom % 2;
      a = 32'h1000 + 32'(($urandom % 4) * 16);
      cur = mem.exists(a) ? mem[a] : '0;
      hit = ($urandom % 2);
      if (hit) begin
        ch = w ? cur[127:64] : {32'($urandom), cur[63:32]};
        cl = w ? cur[63:0]   : {32'($urandom), cur[31:0]};
      end else begin
        ch = {$urandom, $urandom};
        cl = {$urandom, $urandom};
      end
      run_op(w, 0, 1, a, ch, cl, {$urandom, $urandom}, {$urandom, $urandom},
             8'($urandom), "random stream");
    end
    finish_run();
  end
endmodule